// File: doc/BRIEF.md
# Prescaled One-Shot/Periodic Down Timer

A single 32-bit down-counting timer channel with a plain 32-bit register interface. Software programs a start value, picks one-shot or auto-reload operation and sets an 8-bit clock divider. The counter then steps down once per divided tick. When the count runs out, the channel sets its bit in a shared interrupt status word, which software clears by writing a one to it. A level interrupt is raised while that bit is set and interrupts are enabled.

The register port is a simple strobe: one write per cycle selected by `wr_sel`, plus a combinational read mux selected by `rd_sel`. It has no stream data path, so it uses no valid/ready handshake.

Four registers are selected by a 2-bit code: 0 control, 1 start value, 2 live count (read-only), 3 status. Control bit positions are: run enable 30, interrupt enable 29, auto-reload 27, reload command 26, running mirror 25, divider 7:0. Bits 31, 28 and 24:8 are unused.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control word reads 0x00000005 (divider 5, everything else clear), and the start value, live count, status bit and `irq` are all 0.
- R2: While enabled with divider value P, the live count drops by one every P+1 clock cycles. Every reload or 0-to-1 enable restarts the divider, so the first step comes a full P+1 cycles later.
- R3: A control write ignores bits 31, 28 and 24:8, which always read 0. It also ignores the running mirror (bit 25), which keeps its internally kept value.
- R4: A control write with bit 26 set loads the live count from the start value and forces enable (bit 30) to 0 for that write. Bit 26 always reads 0.
- R5: When enable goes 0 to 1, the running mirror is set and counting resumes from the held count. When enable goes 1 to 0, the mirror is cleared and the count freezes.
- R6: If a write clears enable while the held count (after any reload from bit 26) is 0, the expiry action of R7 is taken.
- R7: A step taken at count 1 or 0 is an expiry, and it sets the status bit. In auto-reload mode the count is reloaded from the start value and counting goes on. In one-shot mode the count becomes 0 and both enable and the running mirror are cleared.
- R8: `irq` is high exactly when interrupt enable (bit 29) and the status bit are both set.
- R9: The status bit appears at bit position STAT_BIT of the status register. A status write with a 1 at that bit clears it, and a 0 leaves it unchanged. An expiry in the same cycle wins.
- R10: A write to the start-value register also loads the live count. Writes to the live-count register have no effect.
- R11: Changing the divider while counting keeps the live count and only changes the step rate.
- R12: In a cycle with a control or start-value write, no counting step is taken and the divider does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that the write strobe and select are known every cycle after reset, and that at most one register is written per cycle. The stimulus respects this by changing inputs only on the falling clock edge, with each write lasting one cycle and followed by idle cycles. Reads have no side effects, so the read select is free to move between registers within a cycle. The bench relies on this when it probes every register at the falling edge.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_START = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_STAT  = 2'd3
  } tmr_sel_e;

  localparam int BIT_RUN    = 30;
  localparam int BIT_IEN    = 29;
  localparam int BIT_AUTO   = 27;
  localparam int BIT_RELOAD = 26;
  localparam int BIT_BUSY   = 25;
  localparam int DIV_W      = 8;
  localparam logic [DIV_W-1:0] DIV_RESET = 8'd5;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] div,
  output logic          tick
);
  logic [PW-1:0] phase;

  assign tick = run && (phase >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (restart) phase <= '0;
    else if (tick)    phase <= '0;
    else if (run)     phase <= phase + 1'b1;
  end

  // R2: divider phase only advances by one per running cycle
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> (phase == $past(phase) + 1'b1));
  // R12: divider phase frozen when not running and not restarted
  p_phase_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(phase));
endmodule

// File: rtl/tmr_downcount.sv
`timescale 1ns/1ps
module tmr_downcount #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  input  logic          auto_reload,
  input  logic [DW-1:0] reload_val,
  output logic [DW-1:0] count,
  output logic          expire
);
  localparam logic [DW-1:0] ONE = DW'(1);

  assign expire = step && (count <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_val;
    else if (expire) count <= auto_reload ? reload_val : '0;
    else if (step)   count <= count - ONE;
  end

  // R2: an ordinary step lowers the count by exactly one
  p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && count > ONE) |=> (count == $past(count) - ONE));
  // R7: one-shot expiry leaves the count at zero
  p_oneshot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load && !auto_reload) |=> (count == '0));
  // R7: auto-reload expiry restores the start value
  p_auto_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load && auto_reload) |=> (count == $past(reload_val)));
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DW       = 32,
  parameter int STAT_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [DW-1:0] ZERO = '0;

  logic             run_q, busy_q, ien_q, auto_q, stat_q;
  logic [DIV_W-1:0] div_q;
  logic [DW-1:0]    start_q, count;
  logic             wr_ctrl, wr_start, wr_stat;
  logic             d_reload, d_run, run_rise, fall_expire;
  logic             cnt_load, div_restart, div_run, step, cnt_expire;
  logic [DW-1:0]    held_count, load_val;

  assign wr_ctrl  = wr_en && (wr_sel == SEL_CTRL);
  assign wr_start = wr_en && (wr_sel == SEL_START);
  assign wr_stat  = wr_en && (wr_sel == SEL_STAT);

  assign d_reload    = wr_data[BIT_RELOAD];
  assign d_run       = wr_data[BIT_RUN] && !d_reload;
  assign run_rise    = wr_ctrl && !run_q && d_run;
  assign held_count  = d_reload ? start_q : count;
  assign fall_expire = wr_ctrl && run_q && !d_run && (held_count == ZERO);

  assign cnt_load    = wr_start || (wr_ctrl && d_reload) || (fall_expire && wr_data[BIT_AUTO]);
  assign load_val    = wr_start ? wr_data : start_q;
  assign div_run     = run_q && !wr_ctrl && !wr_start;
  assign div_restart = cnt_load || run_rise;

  tmr_prescaler #(.PW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(div_run), .restart(div_restart),
    .div(div_q), .tick(step)
  );

  tmr_downcount #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(load_val),
    .step(step), .auto_reload(auto_q), .reload_val(start_q),
    .count(count), .expire(cnt_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      busy_q <= 1'b0;
      ien_q  <= 1'b0;
      auto_q <= 1'b0;
      div_q  <= DIV_RESET;
    end else if (wr_ctrl) begin
      run_q  <= d_run;
      busy_q <= d_run;
      ien_q  <= wr_data[BIT_IEN];
      auto_q <= wr_data[BIT_AUTO];
      div_q  <= wr_data[DIV_W-1:0];
    end else if (cnt_expire && !auto_q) begin
      run_q  <= 1'b0;
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        start_q <= '0;
    else if (wr_start) start_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= (stat_q && !(wr_stat && wr_data[STAT_BIT])) || cnt_expire || fall_expire;
  end

  assign irq = ien_q && stat_q;

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_CTRL: begin
        rd_data[BIT_RUN]     = run_q;
        rd_data[BIT_IEN]     = ien_q;
        rd_data[BIT_AUTO]    = auto_q;
        rd_data[BIT_BUSY]    = busy_q;
        rd_data[DIV_W-1:0]   = div_q;
      end
      SEL_START: rd_data = start_q;
      SEL_COUNT: rd_data = count;
      default:   rd_data[STAT_BIT] = stat_q;
    endcase
  end

  // R5: running mirror always follows the enable
  p_busy_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == run_q);
  // R4: a write carrying the reload command leaves the channel stopped
  p_reload_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CTRL && wr_data[BIT_RELOAD]) |=> !run_q);
  // R5: a stopped channel holds its count unless written
  p_hold_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_ctrl && !wr_start) |=> $stable(count));
  // R9: write-one clears the status bit when no expiry competes
  p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wr_data[STAT_BIT] && !cnt_expire) |=> !stat_q);
  // R10: start-value write loads the live count
  p_start_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> (count == $past(wr_data)));
  // R8: interrupt never asserted without its enable
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q && stat_q));
endmodule

// File: tb/tmr_channel_bench.sv
`timescale 1ns/1ps
module tmr_channel_bench;
  localparam logic [31:0] F_RUN  = 32'h4000_0000;
  localparam logic [31:0] F_IEN  = 32'h2000_0000;
  localparam logic [31:0] F_AUTO = 32'h0800_0000;
  localparam logic [31:0] F_RLD  = 32'h0400_0000;
  localparam logic [31:0] F_BUSY = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd2;
  logic [31:0] rd_data;
  logic        irq;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  tmr_channel u_tmr_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit          m_run, m_busy, m_ien, m_auto, m_stat;
  logic [7:0]  m_div;
  int          m_phase;
  logic [31:0] m_start, m_cnt;

  function automatic logic [31:0] m_read(input logic [1:0] sel);
    case (sel)
      2'd0: m_read = (m_run ? F_RUN : 0) | (m_ien ? F_IEN : 0) | (m_auto ? F_AUTO : 0)
                     | (m_busy ? F_BUSY : 0) | {24'd0, m_div};
      2'd1: m_read = m_start;
      2'd2: m_read = m_cnt;
      default: m_read = {31'd0, m_stat};
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit ev = 1'b0;
    bit new_run;
    if (!rst_n) begin
      m_run = 0; m_busy = 0; m_ien = 0; m_auto = 0; m_stat = 0;
      m_div = 8'd5; m_phase = 0; m_start = 0; m_cnt = 0;
      return;
    end
    if (wr_en && wr_sel == 2'd0) begin
      new_run = wr_data[30] && !wr_data[26];
      if (wr_data[26]) begin m_cnt = m_start; m_phase = 0; end
      if (!m_run && new_run) m_phase = 0;
      if (m_run && !new_run && m_cnt == 0) begin
        ev = 1;
        if (wr_data[27]) begin m_cnt = m_start; m_phase = 0; end
      end
      m_run = new_run; m_busy = new_run;
      m_ien = wr_data[29]; m_auto = wr_data[27]; m_div = wr_data[7:0];
    end else if (wr_en && wr_sel == 2'd1) begin
      m_start = wr_data; m_cnt = wr_data; m_phase = 0;
    end else if (m_run) begin
      if (m_phase >= int'(m_div)) begin
        m_phase = 0;
        if (m_cnt <= 1) begin
          ev = 1;
          if (m_auto) m_cnt = m_start;
          else begin m_cnt = 0; m_run = 0; m_busy = 0; end
        end else m_cnt = m_cnt - 1;
      end else m_phase++;
    end
    if (wr_en && wr_sel == 2'd3 && wr_data[0]) m_stat = 0;
    if (ev) m_stat = 1;
  endtask

  // cycle-by-cycle comparison against the reference
  always @(posedge clk) begin
    model_step();
    cycles++;
    #1;
    if (rst_n && !done) begin
      check("R2 live read vs model", rd_data, m_read(rd_sel));
      check("R8 irq vs model", {31'd0, irq}, {31'd0, m_ien && m_stat});
    end
  end

  always @(posedge clk) begin
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic probe(input string tag, input logic [1:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #0.4;
    check(tag, rd_data, exp);
    rd_sel = 2'd2;
    #0.1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R1 control reset", 2'd0, 32'h0000_0005);
    probe("R1 start reset", 2'd1, 32'd0);
    probe("R1 count reset", 2'd2, 32'd0);
    probe("R1 status reset", 2'd3, 32'd0);
    check("R1 irq reset", {31'd0, irq}, 32'd0);

    // one-shot, divider 2: three cycles per step
    wr(2'd1, 32'd4);
    wr(2'd0, F_RUN | F_IEN | 32'd2);
    idle(3);
    probe("R2 first step after full period", 2'd2, 32'd3);
    idle(9);
    probe("R7 one-shot count zero", 2'd2, 32'd0);
    probe("R7 one-shot clears run and busy", 2'd0, F_IEN | 32'd2);
    probe("R7 status set", 2'd3, 32'd1);
    check("R8 irq with enable", {31'd0, irq}, 32'd1);
    wr(2'd3, 32'd0);
    probe("R9 zero write keeps status", 2'd3, 32'd1);
    wr(2'd3, 32'd1);
    probe("R9 one write clears status", 2'd3, 32'd0);
    check("R8 irq drops with status", {31'd0, irq}, 32'd0);

    // auto-reload, divider 0
    wr(2'd1, 32'd2);
    wr(2'd0, F_RUN | F_AUTO);
    idle(2);
    probe("R7 auto-reload restores count", 2'd2, 32'd2);
    probe("R7 auto-reload sets status", 2'd3, 32'd1);
    check("R8 irq masked without enable", {31'd0, irq}, 32'd0);
    idle(4);
    probe("R7 auto-reload keeps running", 2'd0, F_RUN | F_AUTO | F_BUSY);
    wr(2'd0, F_RUN | F_AUTO);
    probe("R12 no step in write cycle", 2'd2, 32'd2);
    wr(2'd3, 32'd1);

    // pause and resume
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd100);
    wr(2'd0, F_RUN);
    idle(5);
    wr(2'd0, 32'd0);
    idle(10);
    probe("R5 frozen count", 2'd2, 32'd95);
    probe("R5 busy cleared", 2'd0, 32'd0);
    wr(2'd0, F_RUN);
    idle(3);
    probe("R5 resumes from held count", 2'd2, 32'd92);
    probe("R5 busy set", 2'd0, F_RUN | F_BUSY);

    // divider change keeps the count
    wr(2'd0, F_RUN | 32'd3);
    probe("R11 count kept on divider change", 2'd2, 32'd92);
    idle(4);
    probe("R11 new step rate", 2'd2, 32'd91);

    // ignored bits
    wr(2'd0, F_RUN | F_BUSY | 32'h01FF_FF00 | 32'h9000_0000 | 32'd3);
    probe("R3 reserved bits ignored", 2'd0, F_RUN | F_BUSY | 32'd3);
    wr(2'd0, F_BUSY);
    probe("R3 busy bit not writable", 2'd0, 32'd0);

    // reload command
    wr(2'd1, 32'd50);
    wr(2'd0, F_RUN);
    idle(3);
    wr(2'd0, F_RUN | F_RLD);
    probe("R4 reload forces stop and self-clears", 2'd0, 32'd0);
    probe("R4 reload loads start value", 2'd2, 32'd50);

    // stop at zero count triggers expiry
    wr(2'd1, 32'd0);
    wr(2'd0, F_RUN | 32'd20);
    wr(2'd0, 32'd0);
    probe("R6 stop at zero sets status", 2'd3, 32'd1);

    // live count is read-only
    wr(2'd2, 32'd123);
    probe("R10 count write ignored", 2'd2, 32'd0);
    wr(2'd1, 32'd7);
    probe("R10 start write loads count", 2'd2, 32'd7);

    wr(2'd0, F_IEN);
    check("R8 irq follows enable", {31'd0, irq}, 32'd1);
    wr(2'd0, 32'd0);
    check("R8 irq off with enable clear", {31'd0, irq}, 32'd0);

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule